// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is the master side of a single-wire, open-drain serial bus with microsecond timing. A start strobe with a two-bit command begins one of three operations: a bus reset followed by a check for an answering device, a write of one byte, or a read of one byte. The block never drives the line high. Its only output toward the line is a pull-low enable; a pad or an external pull-up supplies the high level. The line level comes back in through a synchronizer before any sample is taken.

All phase timing is counted in microsecond ticks. A divider makes one tick from every `CLK_MHZ` system clocks and restarts when an operation is accepted. Every timing is padded for a 3.3 V bus. A byte is carried in eight back-to-back bit slots, least-significant bit first. When an operation ends, the block raises a one-cycle done pulse and leaves the read byte and the device-present flag on its outputs.

Top module: `owm_ctrl`

## Requirements
- R1: Command codes on `cmd_i` are 2'b00 for bus reset, 2'b01 for byte write and 2'b10 for byte read. A `start_i` in a cycle where `busy_o` is low accepts the command, and `busy_o` is high in the next cycle.
- R2: A bus reset asserts `line_pull_o` for exactly 602 us, starting in the cycle after acceptance, and then releases the line.
- R3: During a bus reset the synchronized line is sampled 72 us after the release. If it is low, the operation ends 335 us after the release (937 us after acceptance) and `present_o` becomes 1.
- R4: If the line is high at the 72 us sample, the reset ends at that tick (674 us after acceptance) and `present_o` becomes 0.
- R5: A byte operation runs eight bit slots of 70 us each, with no gap between them. Each slot starts with `line_pull_o` asserted, and the operation ends 560 us after acceptance.
- R6: A write slot holds the line low for 63 us for a 0 bit and for 7 us for a 1 bit. Bit 0 of `wdata_i` goes in the first slot.
- R7: A read slot holds the line low for 7 us, samples the synchronized line 9 us after the slot start, and stores the first sample in bit 0 of `rdata_o`.
- R8: `start_i` has no effect while `busy_o` is high. Command 2'b11 is ignored: `busy_o`, `line_pull_o` and `done_o` all stay low.
- R9: `done_o` pulses high for exactly one cycle when an operation ends, and `busy_o` is low in that same cycle.
- R10: `rdata_o` changes only when a read ends, and `present_o` changes only when a reset ends. Both change in the cycle that `done_o` is high and hold their values until then.
- R11: The line input passes through a two-flop synchronizer. `line_pull_o` is low whenever no operation is running, including right after reset.
- R12: One microsecond equals `CLK_MHZ` clock cycles. Every duration above, measured in cycles, is its microsecond value times `CLK_MHZ`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| cmd_i | input | 2 | Operation code |
| wdata_i | input | 8 | Byte to write, captured at start |
| line_i | input | 1 | Bus line level (asynchronous) |
| line_pull_o | output | 1 | 1 = pull the bus line low, 0 = release |
| busy_o | output | 1 | An operation is running |
| done_o | output | 1 | One-cycle pulse at the end of an operation |
| rdata_o | output | 8 | Last byte read |
| present_o | output | 1 | Result of the last presence check |

## Verification
The reset operation is run twice: once with a modelled device that answers during the sample window, and once with no device. This separates the full-length completion at 937 us from the early completion at 674 us, and checks that the flag is set in one case and cleared in the other. Writes use 0xA5, 0x00 and 0xFF. The mixed pattern shows bit order, the all-zero byte checks the long low pulse in every slot, and the all-ones byte checks the short one. Reads of 0x3C and 0x81 check the sample point and the LSB-first assembly, including both end bits. A start pulsed during a write and a 2'b11 command while idle must leave the line pattern, the done count and the held results unchanged.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [1:0] {
        CMD_BUS_RESET = 2'b00,
        CMD_WRITE     = 2'b01,
        CMD_READ      = 2'b10,
        CMD_NONE      = 2'b11
    } owm_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_RESET = 2'b01,
        ST_SLOT  = 2'b10
    } owm_state_e;

endpackage

// File: rtl/owm_tick.sv
// Microsecond tick generator: one-cycle pulse every CLK_MHZ clocks,
// phase restarted by clear_i.
module owm_tick #(
    parameter int CLK_MHZ = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic tick_o
);
    generate
        if (CLK_MHZ <= 1) begin : g_direct
            assign tick_o = 1'b1;
        end else begin : g_count
            localparam int DIV_W = $clog2(CLK_MHZ);
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_MHZ - 1);

            logic [DIV_W-1:0] cnt_d, cnt_q;

            always_comb begin
                if (clear_i || cnt_q == DIV_LAST) cnt_d = '0;
                else                              cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == DIV_LAST) && !clear_i;
        end
    endgenerate
endmodule

// File: rtl/owm_sync.sv
// Synchronizer chain for the asynchronous bus level; idles high.
module owm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            assign chain_d = async_i;
        end else begin : g_many
            assign chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/owm_seq.sv
// Operation sequencer: reset/presence, write slots and read slots.
module owm_seq
    import owm_pkg::*;
#(
    parameter int T_RSTL = 602,
    parameter int T_MSP  = 72,
    parameter int T_RSTH = 335,
    parameter int T_SLOT = 70,
    parameter int T_W0L  = 63,
    parameter int T_W1L  = 7,
    parameter int T_RL   = 7,
    parameter int T_MSR  = 9,
    parameter int NBITS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             line_s_i,
    input  logic             start_i,
    input  logic [1:0]       cmd_i,
    input  logic [NBITS-1:0] wdata_i,
    output logic             accept_o,
    output logic             pull_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [NBITS-1:0] rdata_o,
    output logic             present_o
);
    localparam int RST_TOTAL = T_RSTL + T_RSTH;
    localparam int US_W      = $clog2(RST_TOTAL + 1);
    localparam int BIT_W     = (NBITS > 1) ? $clog2(NBITS) : 1;

    localparam logic [US_W-1:0]  REL_M1   = US_W'(T_RSTL - 1);
    localparam logic [US_W-1:0]  PSMP_M1  = US_W'(T_RSTL + T_MSP - 1);
    localparam logic [US_W-1:0]  REND_M1  = US_W'(RST_TOTAL - 1);
    localparam logic [US_W-1:0]  SLOT_M1  = US_W'(T_SLOT - 1);
    localparam logic [US_W-1:0]  W0_M1    = US_W'(T_W0L - 1);
    localparam logic [US_W-1:0]  W1_M1    = US_W'(T_W1L - 1);
    localparam logic [US_W-1:0]  RL_M1    = US_W'(T_RL - 1);
    localparam logic [US_W-1:0]  RSMP_M1  = US_W'(T_MSR - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NBITS - 1);

    typedef struct packed {
        owm_state_e       st;
        owm_cmd_e         op;
        logic [US_W-1:0]  us;
        logic [BIT_W-1:0] bitn;
        logic [NBITS-1:0] sh;
        logic [NBITS-1:0] rdata;
        logic             present;
        logic             pull;
        logic             done;
    } seq_t;

    seq_t q, d;
    logic accept;
    logic [US_W-1:0] low_m1;

    assign accept = start_i && (q.st == ST_IDLE) && (owm_cmd_e'(cmd_i) != CMD_NONE);

    always_comb begin
        if (q.op == CMD_WRITE) low_m1 = q.sh[0] ? W1_M1 : W0_M1;
        else                   low_m1 = RL_M1;
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.op   = owm_cmd_e'(cmd_i);
                    d.us   = '0;
                    d.bitn = '0;
                    d.pull = 1'b1;
                    d.sh   = (owm_cmd_e'(cmd_i) == CMD_WRITE) ? wdata_i : '0;
                    d.st   = (owm_cmd_e'(cmd_i) == CMD_BUS_RESET) ? ST_RESET : ST_SLOT;
                end
            end
            ST_RESET: begin
                if (tick_i) begin
                    d.us = q.us + 1'b1;
                    if (q.us == REL_M1) d.pull = 1'b0;
                    if (q.us == PSMP_M1) begin
                        if (line_s_i) begin
                            d.present = 1'b0;
                            d.st      = ST_IDLE;
                            d.done    = 1'b1;
                        end else begin
                            d.sh[0] = 1'b1;
                        end
                    end
                    if (q.us == REND_M1) begin
                        d.present = q.sh[0];
                        d.st      = ST_IDLE;
                        d.done    = 1'b1;
                    end
                end
            end
            ST_SLOT: begin
                if (tick_i) begin
                    d.us = q.us + 1'b1;
                    if (q.us == low_m1) d.pull = 1'b0;
                    if (q.op == CMD_READ && q.us == RSMP_M1)
                        d.sh = {line_s_i, q.sh[NBITS-1:1]};
                    if (q.us == SLOT_M1) begin
                        if (q.bitn == LAST_BIT) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                            if (q.op == CMD_READ) d.rdata = q.sh;
                        end else begin
                            d.us   = '0;
                            d.bitn = q.bitn + 1'b1;
                            d.pull = 1'b1;
                            if (q.op == CMD_WRITE) d.sh = q.sh >> 1;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.op      <= CMD_NONE;
            q.us      <= '0;
            q.bitn    <= '0;
            q.sh      <= '0;
            q.rdata   <= '0;
            q.present <= 1'b0;
            q.pull    <= 1'b0;
            q.done    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign accept_o  = accept;
    assign pull_o    = q.pull;
    assign busy_o    = (q.st != ST_IDLE);
    assign done_o    = q.done;
    assign rdata_o   = q.rdata;
    assign present_o = q.present;
endmodule

// File: rtl/owm_ctrl.sv
// Top level: single-wire bus master controller.
module owm_ctrl #(
    parameter int CLK_MHZ     = 50,
    parameter int SYNC_STAGES = 2,
    parameter int T_RSTL      = 602,
    parameter int T_MSP       = 72,
    parameter int T_RSTH      = 68 + 260 + 5 + 2,
    parameter int T_SLOT      = 70,
    parameter int T_W0L       = 63,
    parameter int T_W1L       = 7,
    parameter int T_RL        = 7,
    parameter int T_MSR       = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] cmd_i,
    input  logic [7:0] wdata_i,
    input  logic       line_i,
    output logic       line_pull_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] rdata_o,
    output logic       present_o
);
    logic tick;
    logic line_s;
    logic accept;

    owm_tick #(.CLK_MHZ(CLK_MHZ)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .tick_o  (tick)
    );

    owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_i),
        .sync_o  (line_s)
    );

    owm_seq #(
        .T_RSTL (T_RSTL),
        .T_MSP  (T_MSP),
        .T_RSTH (T_RSTH),
        .T_SLOT (T_SLOT),
        .T_W0L  (T_W0L),
        .T_W1L  (T_W1L),
        .T_RL   (T_RL),
        .T_MSR  (T_MSR),
        .NBITS  (8)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .line_s_i  (line_s),
        .start_i   (start_i),
        .cmd_i     (cmd_i),
        .wdata_i   (wdata_i),
        .accept_o  (accept),
        .pull_o    (line_pull_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .rdata_o   (rdata_o),
        .present_o (present_o)
    );
endmodule

// File: rtl/owm_ctrl_chk.sv
// Protocol checker bound to the controller top.
module owm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [1:0] cmd_i,
    input logic       line_pull_o,
    input logic       busy_o,
    input logic       done_o,
    input logic [7:0] rdata_o,
    input logic       present_o
);
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && cmd_i != 2'b11) |=> busy_o);                 // R1
    AST_BAD_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && cmd_i == 2'b11) |=> (!busy_o && !line_pull_o)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                  // R9
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                                  // R9
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rdata_o));                                        // R10
    AST_PRESENT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(present_o));                                      // R10
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !line_pull_o);                                            // R11
endmodule

bind owm_ctrl owm_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmd_i       (cmd_i),
    .line_pull_o (line_pull_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rdata_o     (rdata_o),
    .present_o   (present_o)
);

// File: tb/tb_owm_ctrl.sv
`timescale 1ns/1ps
module tb_owm_ctrl;
    localparam int M     = 4;        // clocks per microsecond in this bench
    localparam int NREC  = 4096;
    localparam int SLOTC = 70 * M;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] cmd_i = 2'b00;
    logic [7:0] wdata_i = 8'h00;
    logic       slave_low = 1'b0;
    logic       line_i;
    logic       line_pull_o, busy_o, done_o, present_o;
    logic [7:0] rdata_o;

    int checks = 0;
    int errors = 0;
    int wd_cnt = 0;

    logic pull_rec [NREC];
    logic done_rec [NREC];
    logic busy_rec [NREC];

    always #10 clk = ~clk;   // 50 MHz

    assign line_i = ~(line_pull_o | slave_low);

    owm_ctrl #(.CLK_MHZ(M)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
        .wdata_i(wdata_i), .line_i(line_i), .line_pull_o(line_pull_o),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
        .present_o(present_o)
    );

    always @(posedge clk) begin
        wd_cnt <= wd_cnt + 1;
        if (wd_cnt > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", wd_cnt);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // mode 0: silent, 1: answers reset, 2: returns byte rb on read slots
    function automatic logic slave_fn(input int mode, input logic [7:0] rb, input int i);
        if (mode == 1) return (i >= 602*M + 30*M) && (i < 602*M + 150*M);
        if (mode == 2) begin
            int k = i / SLOTC;
            if (k < 8 && !rb[k]) return (i - k*SLOTC) < 40*M;
        end
        return 1'b0;
    endfunction

    task automatic run_op(input logic [1:0] c, input logic [7:0] wd, input int mode,
                          input logic [7:0] rb, input int n, input bit inject);
        @(negedge clk);
        start_i = 1'b1; cmd_i = c; wdata_i = wd; slave_low = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start_i = 1'b0;
            pull_rec[i] = line_pull_o;
            done_rec[i] = done_o;
            busy_rec[i] = busy_o;
            slave_low   = slave_fn(mode, rb, i);
            if (inject && i == 50) begin start_i = 1'b1; cmd_i = 2'b10; end
        end
        slave_low = 1'b0;
    endtask

    function automatic int first_done(input int n);
        for (int i = 0; i < n; i++) if (done_rec[i]) return i;
        return -1;
    endfunction

    function automatic int done_count(input int n);
        int c = 0;
        for (int i = 0; i < n; i++) if (done_rec[i]) c++;
        return c;
    endfunction

    // number of slots whose low pulse length disagrees with the byte
    function automatic int slot_errs(input logic [7:0] wd, input bit rd);
        int bad = 0;
        for (int k = 0; k < 8; k++) begin
            int len = 0;
            int exp = rd ? 7*M : (wd[k] ? 7*M : 63*M);
            for (int j = 0; j < SLOTC; j++) if (pull_rec[k*SLOTC + j]) len++;
            if (len != exp || !pull_rec[k*SLOTC] || !pull_rec[k*SLOTC + exp - 1]) bad++;
        end
        return bad;
    endfunction

    task automatic t_reset_state();
        chk(!busy_o && !line_pull_o && !done_o, "R11 idle after reset", line_pull_o, 0);
        chk(rdata_o == 8'h00 && !present_o, "R10 results cleared at reset", rdata_o, 0);
    endtask

    task automatic t_reset_present();
        int pulls = 0;
        run_op(2'b00, 8'h00, 1, 8'h00, 3800, 1'b0);
        for (int i = 0; i < 3800; i++) if (pull_rec[i]) pulls++;
        chk(busy_rec[0], "R1 busy after accept", busy_rec[0], 1);
        chk(pulls == 602*M && pull_rec[602*M-1] && !pull_rec[602*M], "R2 reset low time", pulls, 602*M);
        chk(first_done(3800) == 937*M, "R3 reset end with device", first_done(3800), 937*M);
        chk(present_o == 1'b1, "R3 presence seen", present_o, 1);
        chk(!busy_rec[937*M] && busy_rec[937*M-1], "R9 busy falls with done", busy_rec[937*M], 0);
        chk(done_count(3800) == 1, "R9 one done pulse", done_count(3800), 1);
        chk(first_done(3800) == 937*M, "R12 cycles scale with CLK_MHZ", first_done(3800), 937*M);
    endtask

    task automatic t_reset_absent();
        run_op(2'b00, 8'h00, 0, 8'h00, 3800, 1'b0);
        chk(first_done(3800) == 674*M, "R4 early end without device", first_done(3800), 674*M);
        chk(present_o == 1'b0, "R4 presence cleared", present_o, 0);
    endtask

    task automatic t_write(input logic [7:0] wd);
        logic [7:0] rd_before = rdata_o;
        logic       pr_before = present_o;
        run_op(2'b01, wd, 0, 8'h00, 2300, 1'b0);
        chk(slot_errs(wd, 1'b0) == 0, "R6 write pulse widths", slot_errs(wd, 1'b0), 0);
        chk(first_done(2300) == 560*M, "R5 byte length", first_done(2300), 560*M);
        chk(rdata_o == rd_before && present_o == pr_before, "R10 write keeps results",
            rdata_o, rd_before);
    endtask

    task automatic t_read(input logic [7:0] rb);
        logic pr_before = present_o;
        run_op(2'b10, 8'h00, 2, rb, 2300, 1'b0);
        chk(slot_errs(8'h00, 1'b1) == 0, "R7 read pulse widths", slot_errs(8'h00, 1'b1), 0);
        chk(rdata_o == rb, "R7 read byte LSB first", rdata_o, rb);
        chk(first_done(2300) == 560*M, "R5 read byte length", first_done(2300), 560*M);
        chk(present_o == pr_before, "R10 read keeps presence", present_o, pr_before);
    endtask

    task automatic t_start_while_busy();
        logic [7:0] rd_before = rdata_o;
        run_op(2'b01, 8'h5A, 0, 8'h00, 2400, 1'b1);
        chk(slot_errs(8'h5A, 1'b0) == 0, "R8 busy start ignored: pattern", slot_errs(8'h5A, 1'b0), 0);
        chk(done_count(2400) == 1 && !busy_rec[2399], "R8 busy start ignored: one op",
            done_count(2400), 1);
        chk(rdata_o == rd_before, "R8 busy start ignored: rdata", rdata_o, rd_before);
    endtask

    task automatic t_bad_cmd();
        int seen = 0;
        run_op(2'b11, 8'hFF, 0, 8'h00, 200, 1'b0);
        for (int i = 0; i < 200; i++) if (pull_rec[i] || busy_rec[i] || done_rec[i]) seen++;
        chk(seen == 0, "R8 code 11 ignored", seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_reset_present();
        t_write(8'hA5);
        t_write(8'h00);
        t_write(8'hFF);
        t_read(8'h3C);
        t_read(8'h81);
        t_reset_absent();
        t_start_while_busy();
        t_bad_cmd();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule